// File: doc/BRIEF.md
# Parallel Port Service Interrupt and Status Controller

This block is the interrupt, DMA-permission and FIFO-status slice of the extended control register of a parallel port in its fast, FIFO-based transfer mode. Software writes three control bits: a fault-interrupt mask, a DMA enable and a sticky service bit. Software reads those bits back together with two FIFO flags that are computed from the current FIFO occupancy. The block watches an active-low fault line, which it synchronises before use. It raises a one-cycle interrupt on a falling edge of that line. It also raises one when software unmasks the fault interrupt while the fault is already present, so that no fault event is missed between the register read and the register write.

The service bit selects one of three service-interrupt sources and arbitrates them. When it is 0, one source is active and the DMA enable and transfer direction pick which one:
- DMA terminal count, when DMA is enabled;
- enough free FIFO space, when DMA is off and the direction is 0;
- enough stored FIFO bytes, when DMA is off and the direction is 1.

When the active source fires, hardware sets the service bit and pulses the interrupt. While the service bit stays 1, DMA requests and all service sources are held off, until software clears the bit.

Top module: `ecp_service_intr`

## Requirements
- R1: After reset the register reads back with fault mask = 1, DMA enable = 0 and service bit = 1. `irq` and `dma_go` are 0.
- R2: The register layout is as follows.
  - Bit 4 is the fault mask: 1 disables the fault interrupt.
  - Bit 3 is the DMA enable.
  - Bit 2 is the service bit.
  - Bit 1 is the FIFO-full flag and bit 0 is the FIFO-empty flag.
  - Bits 4..2 take the written value on the clock edge where `reg_wr` is 1. Writes to bits 1..0 have no effect.
- R3: While the mask is 0, a high-to-low change of `fault_n` gives an `irq` pulse of exactly one cycle. The pulse is seen in the third cycle after the change: two synchroniser stages, then the edge register. While the mask is 1, a falling edge gives no pulse.
- R4: If the synchronised `fault_n` is low and a write changes the mask from 1 to 0, `irq` pulses for one cycle right after that write edge. A write that leaves the mask at 0 gives no pulse.
- R5: `dma_go` is 1 exactly when DMA enable is 1 and the service bit is 0.
- R6: With DMA enabled and the service bit 0, a `dma_tc` strobe sets the service bit and pulses `irq` on the same edge. In this case the FIFO thresholds are ignored.
- R7: With DMA disabled, direction 0 and the service bit 0, hardware sets the service bit and pulses `irq` on any edge where (DEPTH - `fifo_level`) is at least `wr_thresh`.
- R8: With DMA disabled, direction 1 and the service bit 0, hardware sets the service bit and pulses `irq` on any edge where `fifo_level` is at least `rd_thresh`.
- R9: A threshold input of 0 acts as a threshold of 1.
- R10: The service bit stays 1 until software writes 0 to it. A software write of 1 to the service bit never causes `irq`. On an edge where a write happens, the written value takes priority over a hardware set.
- R11: The full flag is 1 exactly when `fifo_level` equals DEPTH. The empty flag is 1 exactly when `fifo_level` is 0.
- R12: Each hardware set of the service bit produces an `irq` pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Write data, same layout as reg_rdata |
| reg_rdata | output | 5 | Register read data (R2 layout) |
| fifo_level | input | 5 | Bytes currently held in the FIFO, 0..DEPTH |
| wr_thresh | input | 4 | Free-space threshold for direction 0 |
| rd_thresh | input | 4 | Occupancy threshold for direction 1 |
| dma_tc | input | 1 | DMA terminal-count strobe |
| dir | input | 1 | Transfer direction: 0 = host to port, 1 = port to host |
| fault_n | input | 1 | Active-low fault line, asynchronous |
| irq | output | 1 | Interrupt pulse |
| dma_go | output | 1 | DMA requests permitted |

## Verification
A service bit stuck at 1 shows at the ports at once: `dma_go` stays 0, and no `irq` follows when a threshold is met one edge after the bit is cleared. A service bit that fails to hold shows the other way: it reads back 0 on the cycle after a hardware set, and a second `irq` pulse appears. A broken fault edge register or synchroniser shifts the fault pulse away from its fixed third-cycle slot, stretches it, or drops it. The same goes for the unmask path, which must pulse on the very cycle after the write. Each of these faults is therefore visible within one to four cycles of the stimulus that exposes it.

// File: rtl/ecp_svc_pkg.sv
package ecp_svc_pkg;

   // register bit positions (software decodes these)
   localparam int unsigned BIT_EMPTY = 0;
   localparam int unsigned BIT_FULL  = 1;
   localparam int unsigned BIT_SVC   = 2;
   localparam int unsigned BIT_DMAEN = 3;
   localparam int unsigned BIT_FMASK = 4;
   localparam int unsigned REG_W     = 5;

   typedef struct packed {
      logic fmask;
      logic dma_en;
   } ctl_bits_t;

   localparam ctl_bits_t CTL_RESET = '{fmask: 1'b1, dma_en: 1'b0};

endpackage

// File: rtl/ecp_fault_sync.sv
module ecp_fault_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);

   initial begin
      assert (STAGES >= 2)
         else $error("ecp_fault_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE_VAL;
               else        chain[g] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/ecp_fault_irq.sv
module ecp_fault_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_n_s,
   input  logic fmask_q,
   input  logic wr_en,
   input  logic wr_fmask,
   output logic fault_pulse
);

   logic fault_prev;
   logic fell;
   logic unmask_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_prev <= 1'b1;
      else        fault_prev <= fault_n_s;
   end

   assign fell       = fault_prev & ~fault_n_s;
   assign unmask_hit = wr_en & fmask_q & ~wr_fmask & ~fault_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_pulse <= 1'b0;
      else        fault_pulse <= (fell & ~fmask_q) | unmask_hit;
   end

   // R3: a masked edge with no write gives no pulse
   assert_fault_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fmask_q && !wr_en) |=> !fault_pulse);

   // R4: the write path fires only for a 1->0 mask change
   assert_unmask_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmask_q && !fell) |=> !fault_pulse);

endmodule

// File: rtl/ecp_svc_ctrl.sv
module ecp_svc_ctrl #(
   parameter int unsigned DEPTH        = 16,
   parameter int unsigned TH_W         = 4,
   parameter bit          ZERO_AS_ONE  = 1'b1,
   localparam int unsigned LVL_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_svc,
   input  logic             dma_en_q,
   input  logic             dir,
   input  logic             dma_tc,
   input  logic [LVL_W-1:0] level,
   input  logic [TH_W-1:0]  wr_th,
   input  logic [TH_W-1:0]  rd_th,
   output logic             svc_q,
   output logic             set_pulse
);

   localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

   initial begin
      assert ((2 ** TH_W) - 1 <= DEPTH)
         else $error("ecp_svc_ctrl: threshold range exceeds FIFO depth");
   end

   logic [TH_W-1:0]  wr_th_e;
   logic [TH_W-1:0]  rd_th_e;
   logic [LVL_W-1:0] free_bytes;
   logic             space_ok;
   logic             data_ok;
   logic             src_hit;
   logic             set_now;

   generate
      if (ZERO_AS_ONE) begin : g_zero_one
         assign wr_th_e = (wr_th == '0) ? TH_W'(1) : wr_th;
         assign rd_th_e = (rd_th == '0) ? TH_W'(1) : rd_th;
      end else begin : g_zero_raw
         assign wr_th_e = wr_th;
         assign rd_th_e = rd_th;
      end
   endgenerate

   assign free_bytes = DEPTH_L - level;
   assign space_ok   = free_bytes >= LVL_W'(wr_th_e);
   assign data_ok    = level      >= LVL_W'(rd_th_e);

   always_comb begin
      if (dma_en_q)  src_hit = dma_tc;
      else if (dir)  src_hit = data_ok;
      else           src_hit = space_ok;
   end

   assign set_now = ~svc_q & src_hit & ~wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_q     <= 1'b1;
         set_pulse <= 1'b0;
      end else begin
         set_pulse <= set_now;
         if (wr_en)        svc_q <= wr_svc;
         else if (set_now) svc_q <= 1'b1;
      end
   end

   // R10: sticky until software clears it
   assert_svc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_q && !wr_en) |=> svc_q);

   // R10: a software write of 1 never produces a service pulse
   assert_no_sw_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_svc) |=> !set_pulse);

   // R12: the service pulse is never longer than one cycle
   assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> !set_pulse);

   // R12: a pulse always coincides with the bit being set
   assert_pulse_sets_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |-> svc_q);

endmodule

// File: rtl/ecp_fifo_flags.sv
module ecp_fifo_flags #(
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   initial begin
      assert (DEPTH >= 2) else $error("ecp_fifo_flags: DEPTH must be at least 2");
   end

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);

   // R11: the two flags are mutually exclusive
   always_comb begin
      assert_flags_exclusive_R11: assert (!(full && empty));
   end

endmodule

// File: rtl/ecp_service_intr.sv
module ecp_service_intr
   import ecp_svc_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned TH_W        = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ZERO_AS_ONE = 1'b1,
   localparam int unsigned LVL_W      = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [TH_W-1:0]  wr_thresh,
   input  logic [TH_W-1:0]  rd_thresh,
   input  logic             dma_tc,
   input  logic             dir,
   input  logic             fault_n,
   output logic             irq,
   output logic             dma_go
);

   ctl_bits_t ctl_q;
   logic      svc_q;
   logic      svc_pulse;
   logic      fault_pulse;
   logic      fault_n_s;
   logic      full;
   logic      empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
      end else if (reg_wr) begin
         ctl_q.fmask  <= reg_wdata[BIT_FMASK];
         ctl_q.dma_en <= reg_wdata[BIT_DMAEN];
      end
   end

   ecp_fault_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (fault_n),
      .d_sync  (fault_n_s)
   );

   ecp_fault_irq u_fault (
      .clk         (clk),
      .rst_n       (rst_n),
      .fault_n_s   (fault_n_s),
      .fmask_q     (ctl_q.fmask),
      .wr_en       (reg_wr),
      .wr_fmask    (reg_wdata[BIT_FMASK]),
      .fault_pulse (fault_pulse)
   );

   ecp_svc_ctrl #(
      .DEPTH       (DEPTH),
      .TH_W        (TH_W),
      .ZERO_AS_ONE (ZERO_AS_ONE)
   ) u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .wr_svc    (reg_wdata[BIT_SVC]),
      .dma_en_q  (ctl_q.dma_en),
      .dir       (dir),
      .dma_tc    (dma_tc),
      .level     (fifo_level),
      .wr_th     (wr_thresh),
      .rd_th     (rd_thresh),
      .svc_q     (svc_q),
      .set_pulse (svc_pulse)
   );

   ecp_fifo_flags #(
      .DEPTH (DEPTH)
   ) u_flags (
      .level (fifo_level),
      .full  (full),
      .empty (empty)
   );

   always_comb begin
      reg_rdata            = '0;
      reg_rdata[BIT_FMASK] = ctl_q.fmask;
      reg_rdata[BIT_DMAEN] = ctl_q.dma_en;
      reg_rdata[BIT_SVC]   = svc_q;
      reg_rdata[BIT_FULL]  = full;
      reg_rdata[BIT_EMPTY] = empty;
   end

   assign irq    = svc_pulse | fault_pulse;
   assign dma_go = ctl_q.dma_en & ~svc_q;

   // R5: no DMA permission survives a service set
   assert_dma_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      svc_pulse |-> !dma_go);

   // R6: terminal count in DMA mode with the bit clear always sets it
   assert_tc_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_go && dma_tc && !reg_wr) |=> (svc_q && irq));

endmodule

// File: tb/sim_ecp_service_intr.sv
`timescale 1ns/100ps
module sim_ecp_service_intr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [4:0] reg_wdata = '0;
   logic [4:0] reg_rdata;
   logic [4:0] fifo_level = '0;
   logic [3:0] wr_thresh = 4'd4;
   logic [3:0] rd_thresh = 4'd4;
   logic       dma_tc = 1'b0;
   logic       dir = 1'b0;
   logic       fault_n = 1'b1;
   logic       irq;
   logic       dma_go;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ecp_service_intr u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .fifo_level(fifo_level), .wr_thresh(wr_thresh),
      .rd_thresh(rd_thresh), .dma_tc(dma_tc), .dir(dir), .fault_n(fault_n),
      .irq(irq), .dma_go(dma_go)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // advance one edge; inputs change and outputs are sampled 1 ns after it
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // register write: bits {fmask, dma_en, svc}
   task automatic wr(input logic fm, input logic de, input logic sv);
      reg_wr    = 1'b1;
      reg_wdata = {fm, de, sv, 2'b11};
      step();
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
      chk("R1 fmask", reg_rdata[4], 1);
      chk("R1 dma_en", reg_rdata[3], 0);
      chk("R1 svc", reg_rdata[2], 1);
      chk("R1 irq", irq, 0);
      chk("R1 dma_go", dma_go, 0);
   endtask

   task automatic t_flags();
      fifo_level = 5'd0;  #1;
      chk("R11 empty at 0", reg_rdata[1:0], 2'b01);
      fifo_level = 5'd16; #1;
      chk("R11 full at 16", reg_rdata[1:0], 2'b10);
      fifo_level = 5'd7;  #1;
      chk("R11 neither at 7", reg_rdata[1:0], 2'b00);
      wr(1'b1, 1'b0, 1'b1);
      chk("R2 read-only flags ignore write", reg_rdata[1:0], 2'b00);
      chk("R2 layout readback", reg_rdata, 5'b10100);
   endtask

   task automatic t_fault_edge();
      wr(1'b0, 1'b0, 1'b1);
      fault_n = 1'b0;
      step(); chk("R3 no pulse at 1", irq, 0);
      step(); chk("R3 no pulse at 2", irq, 0);
      step(); chk("R3 pulse at 3", irq, 1);
      step(); chk("R3 pulse one cycle", irq, 0);
      fault_n = 1'b1;
      step(); step(); step();
      wr(1'b1, 1'b0, 1'b1);
      fault_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         step(); chk("R3 masked edge silent", irq, 0);
      end
   endtask

   task automatic t_unmask();
      // fault_n is low and synchronised; mask is 1
      wr(1'b0, 1'b0, 1'b1);
      chk("R4 unmask while faulted pulses", irq, 1);
      step(); chk("R4 pulse one cycle", irq, 0);
      wr(1'b0, 1'b0, 1'b1);
      chk("R4 mask 0->0 no pulse", irq, 0);
      wr(1'b1, 1'b0, 1'b1);
      fault_n = 1'b1;
      step(); step(); step();
   endtask

   task automatic t_dma();
      fifo_level = 5'd0; wr_thresh = 4'd1; dir = 1'b0;
      wr(1'b1, 1'b1, 1'b1);
      chk("R5 blocked while svc 1", dma_go, 0);
      wr(1'b1, 1'b1, 1'b0);
      chk("R5 dma_go with svc 0", dma_go, 1);
      step();
      chk("R6 thresholds ignored in DMA mode", reg_rdata[2], 0);
      chk("R6 no irq without tc", irq, 0);
      dma_tc = 1'b1; step(); dma_tc = 1'b0;
      chk("R6 tc sets svc", reg_rdata[2], 1);
      chk("R6 tc irq", irq, 1);
      chk("R5 dma_go dropped", dma_go, 0);
      step();
      chk("R12 irq single cycle", irq, 0);
      chk("R10 svc sticky", reg_rdata[2], 1);
   endtask

   task automatic t_space();
      dir = 1'b0; wr_thresh = 4'd6; fifo_level = 5'd11;
      wr(1'b1, 1'b0, 1'b0);
      step(); step();
      chk("R7 5 free below 6 stays 0", reg_rdata[2], 0);
      chk("R7 no irq below threshold", irq, 0);
      fifo_level = 5'd10;
      step();
      chk("R7 6 free sets svc", reg_rdata[2], 1);
      chk("R7 irq", irq, 1);
      step();
      chk("R12 pulse ends", irq, 0);
   endtask

   task automatic t_data();
      dir = 1'b1; rd_thresh = 4'd9; fifo_level = 5'd8;
      wr(1'b1, 1'b0, 1'b0);
      step();
      chk("R8 8 bytes below 9", reg_rdata[2], 0);
      fifo_level = 5'd9;
      step();
      chk("R8 9 bytes sets svc", reg_rdata[2], 1);
      chk("R8 irq", irq, 1);
   endtask

   task automatic t_zero_thr();
      dir = 1'b1; rd_thresh = 4'd0; fifo_level = 5'd0;
      wr(1'b1, 1'b0, 1'b0);
      step(); step();
      chk("R9 empty FIFO with thr 0 no set", reg_rdata[2], 0);
      fifo_level = 5'd1;
      step();
      chk("R9 one byte meets thr 0", reg_rdata[2], 1);
      chk("R9 irq", irq, 1);
   endtask

   task automatic t_sw_write();
      dir = 1'b0; wr_thresh = 4'd15; fifo_level = 5'd16;
      wr(1'b1, 1'b0, 1'b0);
      chk("R10 svc cleared by write", reg_rdata[2], 0);
      wr(1'b1, 1'b0, 1'b1);
      chk("R10 sw set no irq", irq, 0);
      chk("R10 sw set reads 1", reg_rdata[2], 1);
      step();
      chk("R10 still no irq", irq, 0);
      // condition true during write: write wins, set follows next edge
      fifo_level = 5'd0; wr_thresh = 4'd2;
      wr(1'b1, 1'b0, 1'b0);
      chk("R10 write beats hw set", reg_rdata[2], 0);
      chk("R10 no irq on write edge", irq, 0);
      step();
      chk("R7 set on following edge", reg_rdata[2], 1);
      chk("R12 irq on following edge", irq, 1);
   endtask

   initial begin
      t_reset();
      t_flags();
      t_fault_edge();
      t_unmask();
      t_dma();
      t_space();
      t_data();
      t_zero_thr();
      t_sw_write();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule